// File: doc/BRIEF.md
# Prioritised Vectoring Interrupt Controller

This block gathers thirteen internal interrupt requests, numbered 1 to 13, and presents a single interrupt to the processor. The output is a 3-bit priority level and an 8-bit vector number.

Each source has the following state:
- a pending bit, which tracks its request line;
- an enable-inverting mask bit;
- an 8-bit control byte holding an autovector flag, a 3-bit level and a 2-bit sub-priority.

On every clock the controller looks at the unmasked pending sources and picks the one whose combined level and sub-priority field is largest. It then registers the resulting level and vector.

The vector comes from one of two places. When the autovector flag is set, the vector is 24 plus the level. Otherwise it comes from a dedicated vector register: one for the software watchdog source and one for each of the two serial-port sources. All other sources get a fixed default. Software reaches the control bytes, the mask and the vector registers through a simple single-cycle register port. That port also shows the pending bits.

Top module: `prio_vec_intc`

## Requirements
- R1: A source takes part in arbitration only while its request is high and its mask bit is 0. A mask bit of 1 blocks it, and with no active source both outputs are 0.
- R2: The winner is the active source with the largest value in control bits 4:0. When values are equal, the lowest-numbered source wins.
- R3: When the winning value is below 4, no interrupt is presented, and level and vector are both 0.
- R4: The presented level equals control bits 4:2 of the winning source.
- R5: When control bit 7 of the winner is 1, the vector is 24 plus the level.
- R6: When control bit 7 of the winner is 0, the vector is chosen by source number:
  - source 8 uses the watchdog vector register (address 0x12);
  - source 12 uses the first serial vector register (0x13);
  - source 13 uses the second serial vector register (0x14);
  - every other source gets 0x0F.
- R7: The pending register, read at address 0x11 with source k in bit k, holds the request levels sampled at the last clock edge. Writes to 0x11 have no effect.
- R8: After reset:
  - the control bytes of sources 1 to 13 are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00, 0x00;
  - the mask reads 0x3FFE;
  - the watchdog vector is 0x0F;
  - both serial vectors are 0x00;
  - level and vector outputs are 0.
- R9: The register map is as follows:
  - control byte of source k at address k, in bits 7:0;
  - mask at 0x10, with source k in bit k and bit 0 always reading 0;
  - vector registers in bits 7:0 at their addresses.
  Every other address reads 0.
- R10: The outputs are registered. After a clock edge they reflect the requests sampled at that edge and any register write committed at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_req | input | 13 | Request lines, bit k is source k |
| irq_level | output | 3 | Presented priority level, 0 means none |
| irq_vector | output | 8 | Presented vector number |

## Verification
A register write and a change of the request lines can land on the same clock edge. Examples are a control byte being rewritten while its source rises, or the mask opening while a competing request drops.

The bench provokes this on every step. Each stimulus applies one write together with a new request pattern at the same falling edge. The outputs are then compared after the next rising edge against a model that first applies the write and then arbitrates the new requests.

Directed steps cover the tie, suppression and vector-source cases. A long pseudo-random run mixes control, mask and vector writes with random request patterns.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_MASK  = 5'h10;
    localparam logic [ADDR_W-1:0] A_PEND  = 5'h11;
    localparam logic [ADDR_W-1:0] A_WVEC  = 5'h12;
    localparam logic [ADDR_W-1:0] A_U0VEC = 5'h13;
    localparam logic [ADDR_W-1:0] A_U1VEC = 5'h14;

    typedef struct packed {
        logic [2:0] level;
        logic [7:0] vector;
    } irq_out_t;

    // Power-on control byte for a source number.
    function automatic logic [7:0] ctrl_rst(int idx);
        if (idx >= 1 && idx <= 7) begin
            return 8'(idx * 4);
        end else if (idx == 8) begin
            return 8'h1C;
        end else if (idx >= 9 && idx <= 11) begin
            return 8'h80;
        end else begin
            return 8'h00;
        end
    endfunction

endpackage

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NUM_SRC:1]            req,
    output logic [DATA_W-1:0]           rdata,
    output logic [NUM_SRC:1][7:0]       ctrl_nx,
    output logic [NUM_SRC:1]            mask_nx,
    output logic [NUM_SRC:1]            pend_nx,
    output logic [7:0]                  wvec_nx,
    output logic [7:0]                  u0vec_nx,
    output logic [7:0]                  u1vec_nx
);

    typedef struct packed {
        logic [NUM_SRC:1][7:0] ctrl;
        logic [NUM_SRC:1]      mask;
        logic [NUM_SRC:1]      pend;
        logic [7:0]            wvec;
        logic [7:0]            u0vec;
        logic [7:0]            u1vec;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 1; i <= int'(NUM_SRC); i++) begin
            s.ctrl[i] = ctrl_rst(i);
        end
        s.mask = '1;
        s.wvec = 8'h0F;
        return s;
    endfunction

    localparam state_t RST_ST = reset_state();

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = req;
        if (wr) begin
            for (int i = 1; i <= int'(NUM_SRC); i++) begin
                if (int'(addr) == i) begin
                    st_d.ctrl[i] = wdata[7:0];
                end
            end
            case (addr)
                A_MASK:  st_d.mask  = wdata[NUM_SRC:1];
                A_WVEC:  st_d.wvec  = wdata[7:0];
                A_U0VEC: st_d.u0vec = wdata[7:0];
                A_U1VEC: st_d.u1vec = wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 1; i <= int'(NUM_SRC); i++) begin
            if (int'(addr) == i) begin
                rdata[7:0] = st_q.ctrl[i];
            end
        end
        case (addr)
            A_MASK:  rdata[NUM_SRC:0] = {st_q.mask, 1'b0};
            A_PEND:  rdata[NUM_SRC:0] = {st_q.pend, 1'b0};
            A_WVEC:  rdata[7:0]       = st_q.wvec;
            A_U0VEC: rdata[7:0]       = st_q.u0vec;
            A_U1VEC: rdata[7:0]       = st_q.u1vec;
            default: ;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:NUM_SRC+1], wdata[0]};

    assign ctrl_nx  = st_d.ctrl;
    assign mask_nx  = st_d.mask;
    assign pend_nx  = st_d.pend;
    assign wvec_nx  = st_d.wvec;
    assign u0vec_nx = st_d.u0vec;
    assign u1vec_nx = st_d.u1vec;

    AST_PEND_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> st_q.pend == $past(req)) else $error("pending mismatch"); // R7

    AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_MASK) |=> st_q.mask == $past(wdata[NUM_SRC:1])) else $error("mask write lost"); // R9

endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
    parameter int unsigned NUM_SRC = 13,
    parameter int unsigned IDX_W   = 4
) (
    input  logic [NUM_SRC:1]      active,
    input  logic [NUM_SRC:1][7:0] ctrl,
    output logic                  valid,
    output logic [IDX_W-1:0]      win_idx,
    output logic [7:0]            win_ctrl
);

    localparam int unsigned FLD_W     = 5;
    localparam logic [FLD_W-1:0] MIN_FIELD = 5'd4;

    logic [NUM_SRC:1][FLD_W-1:0] cand;
    logic [FLD_W-1:0]            best;

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_cand
        assign cand[g] = active[g] ? ctrl[g][FLD_W-1:0] : '0;
    end

    // Strictly greater replaces, so equal fields keep the lower number.
    always_comb begin
        best     = '0;
        win_idx  = '0;
        win_ctrl = '0;
        for (int i = 1; i <= int'(NUM_SRC); i++) begin
            if (cand[i] > best) begin
                best     = cand[i];
                win_idx  = IDX_W'(i);
                win_ctrl = ctrl[i];
            end
        end
        valid = (best >= MIN_FIELD);
    end

endmodule

// File: rtl/icu_vector.sv
module icu_vector
    import icu_pkg::*;
#(
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned WDOG_SRC  = 8,
    parameter int unsigned UART0_SRC = 12,
    parameter int unsigned UART1_SRC = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [7:0]       win_ctrl,
    input  logic [7:0]       wvec,
    input  logic [7:0]       u0vec,
    input  logic [7:0]       u1vec,
    output logic [2:0]       level,
    output logic [7:0]       vector
);

    localparam logic [7:0] AUTO_BASE   = 8'd24;
    localparam logic [7:0] DEFAULT_VEC = 8'h0F;

    irq_out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (valid) begin
            out_d.level = win_ctrl[4:2];
            if (win_ctrl[7]) begin
                out_d.vector = AUTO_BASE + {5'b0, win_ctrl[4:2]};
            end else if (win_idx == IDX_W'(WDOG_SRC)) begin
                out_d.vector = wvec;
            end else if (win_idx == IDX_W'(UART0_SRC)) begin
                out_d.vector = u0vec;
            end else if (win_idx == IDX_W'(UART1_SRC)) begin
                out_d.vector = u1vec;
            end else begin
                out_d.vector = DEFAULT_VEC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    logic unused_cbits;
    assign unused_cbits = ^{win_ctrl[6:5], win_ctrl[1:0]};

    assign level  = out_q.level;
    assign vector = out_q.vector;

    AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_q.level == 3'd0) |-> (out_q.vector == 8'd0)) else $error("vector without level"); // R3

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import icu_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 13,
    parameter int unsigned WDOG_SRC  = 8,
    parameter int unsigned UART0_SRC = 12,
    parameter int unsigned UART1_SRC = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_SRC:1]    irq_req,
    output logic [2:0]          irq_level,
    output logic [7:0]          irq_vector
);

    localparam int unsigned IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1][7:0] ctrl_nx;
    logic [NUM_SRC:1]      mask_nx;
    logic [NUM_SRC:1]      pend_nx;
    logic [NUM_SRC:1]      active;
    logic [7:0]            wvec_nx, u0vec_nx, u1vec_nx;
    logic                  win_valid;
    logic [IDX_W-1:0]      win_idx;
    logic [7:0]            win_ctrl;

    icu_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .req      (irq_req),
        .rdata    (reg_rdata),
        .ctrl_nx  (ctrl_nx),
        .mask_nx  (mask_nx),
        .pend_nx  (pend_nx),
        .wvec_nx  (wvec_nx),
        .u0vec_nx (u0vec_nx),
        .u1vec_nx (u1vec_nx)
    );

    assign active = pend_nx & ~mask_nx;

    icu_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .active   (active),
        .ctrl     (ctrl_nx),
        .valid    (win_valid),
        .win_idx  (win_idx),
        .win_ctrl (win_ctrl)
    );

    icu_vector #(
        .IDX_W     (IDX_W),
        .WDOG_SRC  (WDOG_SRC),
        .UART0_SRC (UART0_SRC),
        .UART1_SRC (UART1_SRC)
    ) u_vec (
        .clk      (clk),
        .rst      (rst),
        .valid    (win_valid),
        .win_idx  (win_idx),
        .win_ctrl (win_ctrl),
        .wvec     (wvec_nx),
        .u0vec    (u0vec_nx),
        .u1vec    (u1vec_nx),
        .level    (irq_level),
        .vector   (irq_vector)
    );

    AST_NO_REQ_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (irq_req == '0) |=> (irq_level == 3'd0 && irq_vector == 8'd0)) else $error("irq without request"); // R1

    AST_FULL_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_MASK && (&reg_wdata[NUM_SRC:1])) |=> (irq_level == 3'd0)) else $error("masked irq shown"); // R1

endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
    import icu_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [13:1] irq_req;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  m_ctrl [1:13];
    logic [13:1] m_mask;
    logic [13:1] m_req;
    logic [7:0]  m_wv, m_u0, m_u1;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    prio_vec_intc dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [10:0] model();
        int best = 0;
        int win  = 0;
        logic [2:0] l;
        logic [7:0] v;
        for (int i = 1; i <= 13; i++) begin
            if (m_req[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > best) begin
                best = int'(m_ctrl[i][4:0]);
                win  = i;
            end
        end
        if (best < 4) return 11'd0;
        l = m_ctrl[win][4:2];
        if (m_ctrl[win][7]) v = 8'd24 + 8'(l);
        else if (win == 8)  v = m_wv;
        else if (win == 12) v = m_u0;
        else if (win == 13) v = m_u1;
        else                v = 8'h0F;
        return {l, v};
    endfunction

    task automatic step(input logic do_wr, input logic [4:0] a, input logic [15:0] d,
                        input logic [13:1] r, input string tag);
        @(negedge clk);
        reg_wr = do_wr; reg_addr = a; reg_wdata = d; irq_req = r;
        @(negedge clk);
        reg_wr = 1'b0;
        m_req = r;
        if (do_wr) begin
            if (a >= 5'd1 && a <= 5'd13) m_ctrl[a] = d[7:0];
            else if (a == A_MASK)  m_mask = d[13:1];
            else if (a == A_WVEC)  m_wv = d[7:0];
            else if (a == A_U0VEC) m_u0 = d[7:0];
            else if (a == A_U1VEC) m_u1 = d[7:0];
        end
        check(tag, {21'd0, irq_level, irq_vector}, {21'd0, model()});
    endtask

    task automatic check_rd(input logic [4:0] a, input logic [15:0] expv, input string tag);
        reg_addr = a;
        #1;
        check(tag, {16'd0, reg_rdata}, {16'd0, expv});
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; irq_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state, read back over the register map (R9)
        m_ctrl[1] = 8'h04; m_ctrl[2] = 8'h08; m_ctrl[3] = 8'h0C; m_ctrl[4] = 8'h10;
        m_ctrl[5] = 8'h14; m_ctrl[6] = 8'h18; m_ctrl[7] = 8'h1C; m_ctrl[8] = 8'h1C;
        m_ctrl[9] = 8'h80; m_ctrl[10] = 8'h80; m_ctrl[11] = 8'h80;
        m_ctrl[12] = 8'h00; m_ctrl[13] = 8'h00;
        m_mask = '1; m_req = '0; m_wv = 8'h0F; m_u0 = 8'h00; m_u1 = 8'h00;
        check("R8 reset level", {29'd0, irq_level}, 32'd0);
        check("R8 reset vector", {24'd0, irq_vector}, 32'd0);
        for (int k = 1; k <= 13; k++) check_rd(5'(k), {8'd0, m_ctrl[k]}, "R8 reset ctrl");
        check_rd(A_MASK, 16'h3FFE, "R8 reset mask");
        check_rd(A_WVEC, 16'h000F, "R8 reset wdog vector");
        check_rd(A_U0VEC, 16'h0000, "R8 reset serial0 vector");
        check_rd(A_U1VEC, 16'h0000, "R8 reset serial1 vector");
        check_rd(A_PEND, 16'h0000, "R7 reset pending");
        check_rd(5'd0, 16'h0000, "R9 unmapped 0x00");
        check_rd(5'h1F, 16'h0000, "R9 unmapped 0x1F");

        // R1 everything masked after reset
        step(1'b0, 5'd0, 16'd0, 13'h1FFF, "R1 all masked");

        // R9 mask write, bit 0 reads back 0
        step(1'b1, A_MASK, 16'hFFFF, 13'h1FFF, "R1 mask all");
        check_rd(A_MASK, 16'h3FFE, "R9 mask bit0 reads 0");
        step(1'b1, A_MASK, 16'h0000, 13'h0000, "R1 open mask no req");

        // R3 R4 R6 single sources with reset control bytes
        for (int k = 1; k <= 13; k++) step(1'b0, 5'd0, 16'd0, 13'(1 << (k - 1)), "R3 R4 R6 single source");

        // R6 dedicated vector registers
        step(1'b1, A_WVEC, 16'h0040, 13'h0000, "R6 write wvec");
        step(1'b1, A_U0VEC, 16'h0041, 13'h0000, "R6 write u0");
        step(1'b1, A_U1VEC, 16'h0042, 13'h0000, "R6 write u1");
        step(1'b1, 5'd8, 16'h0014, 13'h0080, "R6 wdog source vector");
        step(1'b1, 5'd12, 16'h0018, 13'h0800, "R6 serial0 vector");
        step(1'b1, 5'd13, 16'h000C, 13'h1000, "R6 serial1 vector");
        step(1'b1, 5'd12, 16'h0098, 13'h0800, "R5 autovector 30");
        step(1'b1, 5'd3, 16'h009F, 13'h0004, "R5 autovector 31");
        step(1'b1, 5'd3, 16'h0003, 13'h0004, "R3 field 3 suppressed");

        // R2 ties: equal fields, lowest unmasked number wins
        for (int k = 1; k <= 13; k++) step(1'b1, 5'(k), 16'h0010, 13'h1FFF, "R2 tie setup");
        for (int k = 1; k <= 13; k++)
            step(1'b1, A_MASK, 16'(((1 << k) - 1) & 16'h3FFE), 13'h1FFF, "R2 tie lowest wins");

        // R7 pending follows requests, write ignored
        step(1'b1, A_PEND, 16'hFFFF, 13'h0A5A, "R7 pending write");
        check_rd(A_PEND, 16'h14B4, "R7 pending read after write");
        step(1'b0, 5'd0, 16'd0, 13'h1234, "R7 pending change");
        check_rd(A_PEND, 16'h2468, "R7 pending tracks");

        // R10 same-edge write and request change, pseudo-random
        for (int t = 0; t < 400; t++) begin
            logic [4:0] a;
            seed = xs(seed);
            case (seed[3:0])
                4'd13:   a = A_MASK;
                4'd14:   a = (seed[5]) ? A_U0VEC : A_WVEC;
                4'd15:   a = (seed[5]) ? A_U1VEC : A_PEND;
                default: a = 5'(seed[3:0]) + 5'd1;
            endcase
            if (a == A_MASK) step(1'b1, a, {2'b0, seed[30:18] & seed[17:5], 1'b0}, seed[31:19], "R10 R1 random mask");
            else step(seed[6] | seed[7], a, seed[23:8], seed[31:19], "R10 R2 R4 R5 R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule